// File: doc/BRIEF.md
# RS-485 Serial Transmitter with Line Direction Control

This block is the transmit half of an asynchronous serial port. It drives a half-duplex RS-485 transceiver. Bytes written into a parameterised FIFO are sent one after another on a single serial line. Each character carries a low start bit, five to eight data bits with the least significant bit first, an optional even or odd parity bit and one or two high stop bits. Every bit lasts sixteen pulses of an externally supplied 16x baud tick, and the line rests high between characters.

The block also drives the transceiver's direction pin by itself. The pin goes low (driver on) as soon as a byte is accepted. It stays low through any run of queued characters that follow one another with no gap. It goes back high (receiver on) only once the final stop bit of the final queued character has completely left the shifter. Direction control works only when two independent enable inputs are both 1. Otherwise, and after reset, the pin sits at its receive level. A write to a full FIFO is dropped and raises a sticky overflow flag.

Top module: `rs485_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `dir_n` is 1, `busy` is 0 and `overflow` is 0.
- R2: A character is one start bit at 0, then `len_sel`+5 data bits sent LSB first (00 selects 5 bits, 11 selects 8), then stop bits at 1. Each bit lasts exactly 16 `baud_tick` pulses.
- R3: With `par_en`=1, a parity bit follows the data bits. With `par_odd`=0 the data ones plus the parity bit make an even count. With `par_odd`=1 they make an odd count.
- R4: With `two_stop`=1, two stop bits (32 ticks of 1) end each character. Otherwise one stop bit ends it.
- R5: If another byte is queued when the last stop bit ends, its start bit begins on that same clock edge with no idle gap. `busy` stays 1 and `dir_n` stays 0 across the join.
- R6: A byte written while the transmitter is idle drives `txd` to 0 on the second clock edge after the write cycle. The first edge stores the byte and the second starts the frame.
- R7: With both enables at 1, an accepted write drives `dir_n` to 0 on the clock edge that accepts it.
- R8: With both enables at 1, `dir_n` returns to 1 one clock edge after the edge that ends the final stop bit with the FIFO empty.
- R9: While `dir_en_a` or `dir_en_b` is 0, `dir_n` is 1 regardless of traffic.
- R10: A write while the FIFO holds `DEPTH` bytes is ignored, so that byte is never sent. It sets `overflow`, which stays 1 until reset.
- R11: `busy` is 1 while any byte is queued or being sent, and `txd` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | 8 | Byte to queue; only the low `len_sel`+5 bits are sent |
| len_sel | input | 2 | Data length: value + 5 bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| dir_en_a | input | 1 | First direction-control enable |
| dir_en_b | input | 1 | Second direction-control enable |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| txd | output | 1 | Serial data line, idle high |
| dir_n | output | 1 | Transceiver direction: 0 transmit, 1 receive |
| busy | output | 1 | A byte is queued or on the line |
| overflow | output | 1 | Sticky: a write hit a full FIFO |

## Verification
A stored byte is visible on `busy` and `dir_n` one edge after its write cycle. Its start bit appears one edge later. Each following bit changes `txd` on the edge that takes the sixteenth tick of the previous bit, and `dir_n` is released one edge after the last stop bit ends. The bench drives inputs on the falling edge and advances a behavioural queue model on each rising edge. It compares every output on the following falling edge, so each expected value already includes those register delays. Focused checks sample at exactly those edges: the write edge for direction, the second edge for the start bit, and the edge after the final stop for release. The overflow test fills the FIFO before the first start bit ends, so the extra write meets a full FIFO.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
  localparam int TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/rs485_tx_fifo.sv
module rs485_tx_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             nonempty,
  output logic             full,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             wr_ok;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign wr_ok    = wr_en && !full;

  // plain dual-port memory with registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rs485_tx_framer.sv
module rs485_tx_framer
  import rs485_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  frame_cfg_t cfg,
  input  logic       have_data,
  input  logic [7:0] rd_data,
  output logic       pop,
  output logic       txd,
  output logic       active
);
  localparam int TW = $clog2(TICKS_PER_BIT);

  tx_state_e     state;
  logic [TW-1:0] tick_cnt;
  logic [2:0]    bit_idx;
  logic [2:0]    last_idx;
  logic          second_stop;
  logic [7:0]    shreg;
  logic          par_bit;
  logic [7:0]    mask;
  logic          bit_end;

  assign last_idx = {1'b1, cfg.len_sel};
  assign bit_end  = baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
  assign pop      = (state == ST_START) && bit_end;
  assign active   = (state != ST_IDLE);

  always_comb begin
    for (int i = 0; i < 8; i++) mask[i] = (3'(i) <= last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tick_cnt    <= '0;
      bit_idx     <= '0;
      second_stop <= 1'b0;
      shreg       <= '0;
      par_bit     <= 1'b0;
      txd         <= 1'b1;
    end else begin
      if (state != ST_IDLE && baud_tick) tick_cnt <= tick_cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          tick_cnt <= '0;
          txd      <= 1'b1;
          if (have_data) begin
            state <= ST_START;
            txd   <= 1'b0;
          end
        end
        ST_START: if (bit_end) begin
          shreg   <= rd_data >> 1;
          txd     <= rd_data[0];
          par_bit <= (^(rd_data & mask)) ^ cfg.par_odd;
          bit_idx <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          if (bit_idx == last_idx) begin
            second_stop <= 1'b0;
            if (cfg.par_en) begin
              state <= ST_PARITY;
              txd   <= par_bit;
            end else begin
              state <= ST_STOP;
              txd   <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            txd     <= shreg[0];
            shreg   <= shreg >> 1;
          end
        end
        ST_PARITY: if (bit_end) begin
          state <= ST_STOP;
          txd   <= 1'b1;
        end
        ST_STOP: if (bit_end) begin
          if (cfg.two_stop && !second_stop) begin
            second_stop <= 1'b1;
          end else if (have_data) begin
            state <= ST_START;
            txd   <= 1'b0;
          end else begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en_a,
  input  logic en_b,
  input  logic wr_accept,
  input  logic pending,
  output logic dir_n
);
  always_ff @(posedge clk) begin
    if (rst) dir_n <= 1'b1;
    else     dir_n <= !(en_a && en_b && (wr_accept || pending));
  end
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
  import rs485_tx_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       dir_en_a,
  input  logic       dir_en_b,
  input  logic       baud_tick,
  output logic       txd,
  output logic       dir_n,
  output logic       busy,
  output logic       overflow
);
  frame_cfg_t cfg;
  logic       pop, nonempty, full, frame_active;
  logic [7:0] rd_data;

  assign cfg  = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
  assign busy = frame_active || nonempty;

  rs485_tx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .nonempty(nonempty), .full(full), .overflow(overflow)
  );

  rs485_tx_framer u_framer (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg(cfg), .have_data(nonempty),
    .rd_data(rd_data), .pop(pop), .txd(txd), .active(frame_active)
  );

  rs485_dir_ctrl u_dir (
    .clk(clk), .rst(rst), .en_a(dir_en_a), .en_b(dir_en_b),
    .wr_accept(wr_en && !full), .pending(busy), .dir_n(dir_n)
  );
endmodule

// File: rtl/rs485_uart_tx_chk.sv
module rs485_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic dir_n,
  input logic busy,
  input logic overflow,
  input logic dir_en_a,
  input logic dir_en_b
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (txd && dir_n && !busy && !overflow));
  // R9
  a_r9_dir_disabled: assert property (@(posedge clk) disable iff (rst)
    !(dir_en_a && dir_en_b) |=> dir_n);
  // R8
  a_r8_dir_held_while_busy: assert property (@(posedge clk) disable iff (rst)
    (dir_en_a && dir_en_b && busy) |=> !dir_n);
  // R10
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R11
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

bind rs485_uart_tx rs485_uart_tx_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .dir_n(dir_n), .busy(busy),
  .overflow(overflow), .dir_en_a(dir_en_a), .dir_en_b(dir_en_b)
);

// File: tb/rs485_uart_tx_tb.sv
module rs485_uart_tx_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] len_sel = 2'b11;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic dir_en_a = 1'b0, dir_en_b = 1'b0;
  logic baud_tick = 1'b0;
  logic txd, dir_n, busy, overflow;

  always #4 clk = ~clk;

  rs485_uart_tx #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .dir_en_a(dir_en_a), .dir_en_b(dir_en_b), .baud_tick(baud_tick),
    .txd(txd), .dir_n(dir_n), .busy(busy), .overflow(overflow)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  int tick_div = 2, tick_phase = 0;
  bit finished = 0;
  string cur_req = "R2";

  // behavioural reference
  byte unsigned q[$];
  int bits[$];
  int pos, tks;
  bit infr, m_txd, m_dirn, m_busy, m_ovf;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void build(byte unsigned b);
    int nb = 5 + int'(len_sel);
    int ones = 0;
    bits.delete();
    bits.push_back(0);
    for (int i = 0; i < nb; i++) begin
      bits.push_back(int'(b[i]));
      ones += int'(b[i]);
    end
    if (par_en) bits.push_back(par_odd ? 1 - (ones % 2) : ones % 2);
    bits.push_back(1);
    if (two_stop) bits.push_back(1);
  endfunction

  function automatic void model_reset();
    q.delete();
    infr = 0; m_txd = 1; m_dirn = 1; m_busy = 0; m_ovf = 0;
    pos = 0; tks = 0;
  endfunction

  function automatic void model_edge();
    int qs = q.size();
    bit busy_old = infr || (qs > 0);
    bit acc = wr_en && (qs < DEPTH);
    if (wr_en && !acc) m_ovf = 1;
    if (!infr) begin
      if (qs > 0) begin
        build(q[0]); pos = 0; tks = 0; infr = 1; m_txd = 0;
      end
    end else if (baud_tick) begin
      tks++;
      if (tks == 16) begin
        tks = 0;
        if (pos == 0) void'(q.pop_front());
        pos++;
        if (pos == bits.size()) begin
          if (q.size() > 0) begin
            build(q[0]); pos = 0; m_txd = 0;
          end else begin
            infr = 0; m_txd = 1;
          end
        end else m_txd = bits[pos][0];
      end
    end
    m_dirn = !(dir_en_a && dir_en_b && (acc || busy_old));
    if (acc) q.push_back(wr_data);
    m_busy = infr || (q.size() > 0);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step();
    baud_tick = (tick_phase == 0);
    tick_phase = (tick_phase + 1) % tick_div;
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    check(txd === m_txd, cur_req, "txd", int'(txd), int'(m_txd));
    check(dir_n === m_dirn, "R7", "dir_n", int'(dir_n), int'(m_dirn));
    check(busy === m_busy, "R11", "busy", int'(busy), int'(m_busy));
    check(overflow === m_ovf, "R10", "overflow", int'(overflow), int'(m_ovf));
  endtask

  task automatic write_byte(byte unsigned b);
    wr_en = 1'b1; wr_data = b;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && m_busy; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int gap;
    int dir_low;
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    check(txd && dir_n && !busy && !overflow, "R1", "reset outputs",
          int'({txd, dir_n, busy, overflow}), 4'b1100);

    // 8N1, direction enabled
    dir_en_a = 1; dir_en_b = 1; cur_req = "R2";
    write_byte(8'hA5);
    check(dir_n == 1'b0, "R7", "dir_n on write edge", int'(dir_n), 0);
    check(txd == 1'b1, "R6", "txd one edge after write", int'(txd), 1);
    step();
    check(txd == 1'b0, "R6", "start bit at second edge", int'(txd), 0);
    wait_idle();
    check(dir_n == 1'b0, "R8", "dir_n at final stop end", int'(dir_n), 0);
    step();
    check(dir_n == 1'b1, "R8", "dir_n released next edge", int'(dir_n), 1);

    // 5-bit, tick every clock
    tick_div = 1; len_sel = 2'b00;
    write_byte(8'hF3); wait_idle(); step();

    // even parity, 7 bits
    cur_req = "R3"; tick_div = 3; len_sel = 2'b10; par_en = 1; par_odd = 0;
    write_byte(8'h6B); wait_idle(); step();
    // odd parity, 8 bits
    len_sel = 2'b11; par_odd = 1;
    write_byte(8'h81); wait_idle(); step();

    // two stop bits, 6-bit odd parity
    cur_req = "R4"; tick_div = 2; len_sel = 2'b01; two_stop = 1;
    write_byte(8'h2C); wait_idle(); step();
    two_stop = 0; par_en = 0; par_odd = 0; len_sel = 2'b11;

    // back-to-back
    cur_req = "R5";
    write_byte(8'h3C); write_byte(8'hC3);
    gap = 0; dir_low = 0;
    for (int i = 0; i < 5000 && m_busy; i++) begin
      step();
      if (m_busy && !busy) gap++;
      if (m_busy && dir_n) gap++;
    end
    check(gap == 0, "R5", "gap cycles between characters", gap, 0);
    step();

    // direction disabled by either enable
    cur_req = "R9"; dir_en_b = 0;
    write_byte(8'h55);
    for (int i = 0; i < 5000 && m_busy; i++) begin
      step();
      if (!dir_n) dir_low++;
    end
    check(dir_low == 0, "R9", "dir_n low cycles (en_b=0)", dir_low, 0);
    dir_en_b = 1; dir_en_a = 0; dir_low = 0;
    write_byte(8'hAA);
    for (int i = 0; i < 5000 && m_busy; i++) begin
      step();
      if (!dir_n) dir_low++;
    end
    check(dir_low == 0, "R9", "dir_n low cycles (en_a=0)", dir_low, 0);
    dir_en_a = 1; step();

    // overflow: five writes into a four-deep queue
    cur_req = "R10";
    for (int i = 0; i < DEPTH; i++) write_byte(8'h10 + 8'(i));
    check(overflow == 1'b0, "R10", "overflow before extra write", int'(overflow), 0);
    write_byte(8'hEE);
    check(overflow == 1'b1, "R10", "overflow after write when full", int'(overflow), 1);
    check(busy == 1'b1, "R11", "busy while queued", int'(busy), 1);
    wait_idle(); step();
    check(overflow == 1'b1, "R10", "overflow sticky", int'(overflow), 1);

    rst = 1'b1; step(); rst = 1'b0;
    check(!overflow && dir_n && txd && !busy, "R1", "outputs after second reset",
          int'({txd, dir_n, busy, overflow}), 4'b1100);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule